// File: doc/BRIEF.md
# Wide Immediate Move Unit

This execution unit builds a destination register value from a 16-bit immediate placed in one 16-bit aligned lane. There are three merge policies. The zero policy clears every bit outside the lane. The inverting policy returns the bitwise complement of the zero-policy value. The keep policy writes the lane over the current destination value and leaves the other bits as they were. An operand-width bit selects 64-bit or 32-bit operation. In 32-bit mode only lanes 0 and 1 exist. The current destination value matters only to the keep policy, and to the error case where it is passed through unchanged.

A strobe registers one request, and the result appears on the cycle after it. A separate combinational classifier takes a 32-bit or 64-bit constant and reports which single operation can produce it: the zero policy, the inverting policy, or neither. It also reports the lane and immediate that operation would need. Instruction decode and register-file access stay outside the unit.

Top module: `wimm_move_unit`

## Requirements
- R1: With `mv_op` = 0 (zero policy) and a legal lane, the result is `mv_imm` shifted left by 16 times `mv_lane`, with every other bit cleared.
- R2: With `mv_op` = 1 (inverting policy) and a legal lane, the result is the bitwise complement of the zero-policy value within the operand width.
- R3: With `mv_op` = 2 (keep policy) and a legal lane, result bits 16*lane+15 down to 16*lane equal `mv_imm`, and every other bit within the operand width equals `mv_dest`.
- R4: In 32-bit mode (`mv_wide` = 0) with a legal lane, result bits 63:32 are zero for every policy.
- R5: In 32-bit mode a lane of 2 or 3 sets `res_err` to 1 and makes the result equal to `mv_dest` in all 64 bits. Legal requests give `res_err` = 0.
- R6: `mv_op` = 3 is reserved. It sets `res_err` to 1 and makes the result equal to `mv_dest`.
- R7: `res_valid` is high for exactly the cycle after each cycle in which `mv_valid` is high, and strobes on consecutive cycles give results on consecutive cycles. Without a strobe, `res_result` and `res_err` keep their last values.
- R8: While `rst` is high, the next clock edge forces `res_valid`, `res_err` and `res_result` to zero.
- R9: The classifier reports `cls_form` = 1 (zero policy) when the constant, within the width chosen by `cls_wide`, has non-zero bits in at most one lane. `cls_lane` and `cls_imm` then give that lane and its contents. An all-zero constant gives lane 0 and immediate 0.
- R10: When the zero policy cannot build the constant but the complement of the constant within the width has non-zero bits in at most one lane, the classifier reports `cls_form` = 2 (inverting policy), with that lane and the complemented lane contents as the immediate. When both policies could build the constant, the zero policy is reported.
- R11: When neither policy can build the constant, `cls_form` = 0, and `cls_lane` and `cls_imm` are zero.
- R12: With `cls_wide` = 0, bits 63:32 of `cls_value` have no effect on any classifier output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mv_valid | input | 1 | Request strobe |
| mv_op | input | 2 | Policy: 0 zero, 1 inverting, 2 keep, 3 reserved |
| mv_imm | input | 16 | Immediate placed in the selected lane |
| mv_lane | input | 2 | Lane index; the bit position is 16 times this value |
| mv_wide | input | 1 | 1 for 64-bit operation, 0 for 32-bit |
| mv_dest | input | 64 | Current destination value |
| res_valid | output | 1 | Result valid, one cycle after the strobe |
| res_result | output | 64 | New destination value |
| res_err | output | 1 | Illegal lane or reserved policy |
| cls_value | input | 64 | Constant to classify |
| cls_wide | input | 1 | Width of the constant: 1 for 64-bit, 0 for 32-bit |
| cls_form | output | 2 | 0 none, 1 zero policy, 2 inverting policy |
| cls_lane | output | 2 | Lane for the reported policy |
| cls_imm | output | 16 | Immediate for the reported policy |

## Verification
A wrong lane select or merge term shows on `res_result` at the sample point one cycle after the strobe, as a stale lane, a leaked neighbour lane or a non-zero upper word. The scoreboard compares each value against a model computed from the requirements. A stuck or skewed valid register shows at once as a missing, duplicated or shifted result, and the scoreboard queue then runs out of step. The classifier has no state, so a wrong lane detect or a wrong preference is visible on its outputs as soon as the constant is applied.

// File: rtl/wimm_pkg.sv
package wimm_pkg;
    localparam int unsigned WIMM_DATA_W = 64;
    localparam int unsigned WIMM_LANE_W = 16;
    localparam int unsigned WIMM_LANES  = WIMM_DATA_W / WIMM_LANE_W;
    localparam int unsigned WIMM_SEL_W  = $clog2(WIMM_LANES);
    localparam int unsigned WIMM_HALF_W = WIMM_DATA_W / 2;

    typedef enum logic [1:0] {
        MV_ZERO = 2'd0,
        MV_NOT  = 2'd1,
        MV_KEEP = 2'd2,
        MV_RSVD = 2'd3
    } mv_op_e;

    typedef enum logic [1:0] {
        FORM_NONE = 2'd0,
        FORM_ZERO = 2'd1,
        FORM_NOT  = 2'd2
    } mv_form_e;

    typedef struct packed {
        mv_op_e                  op;
        logic [WIMM_SEL_W-1:0]   lane;
        logic                    wide;
        logic [WIMM_LANE_W-1:0]  imm;
    } mv_ctl_t;

    typedef struct packed {
        logic                    err;
        logic [WIMM_DATA_W-1:0]  value;
    } mv_res_t;

    // Lane exists for the chosen width and the policy is not reserved.
    function automatic logic req_legal(mv_ctl_t c);
        logic lane_ok;
        lane_ok = c.wide || (int'(c.lane) < int'(WIMM_LANES / 2));
        return lane_ok && (c.op != MV_RSVD);
    endfunction
endpackage

// File: rtl/wimm_lane_merge.sv
module wimm_lane_merge
    import wimm_pkg::*;
#(
    parameter int unsigned DATA_W = WIMM_DATA_W,
    parameter int unsigned LANE_W = WIMM_LANE_W,
    localparam int unsigned NL    = DATA_W / LANE_W,
    localparam int unsigned SEL_W = $clog2(NL)
) (
    input  mv_op_e              op,
    input  logic [SEL_W-1:0]    lane,
    input  logic                wide,
    input  logic [LANE_W-1:0]   imm,
    input  logic [DATA_W-1:0]   dest,
    output logic [DATA_W-1:0]   merged
);
    for (genvar g = 0; g < NL; g++) begin : g_lane
        logic [LANE_W-1:0] base;
        logic [LANE_W-1:0] lane_val;

        always_comb begin
            if (lane == SEL_W'(g)) begin
                base = imm;
            end else if (op == MV_KEEP) begin
                base = dest[g*LANE_W +: LANE_W];
            end else begin
                base = '0;
            end
            lane_val = (op == MV_NOT) ? ~base : base;
        end

        if (g >= NL / 2) begin : g_upper
            assign merged[g*LANE_W +: LANE_W] = wide ? lane_val : '0;
        end else begin : g_lower
            assign merged[g*LANE_W +: LANE_W] = lane_val;
        end
    end
endmodule

// File: rtl/wimm_form_detect.sv
module wimm_form_detect
    import wimm_pkg::*;
#(
    parameter int unsigned DATA_W = WIMM_DATA_W,
    parameter int unsigned LANE_W = WIMM_LANE_W,
    localparam int unsigned NL    = DATA_W / LANE_W,
    localparam int unsigned SEL_W = $clog2(NL),
    localparam int unsigned HALF  = DATA_W / 2
) (
    input  logic [DATA_W-1:0]   value,
    input  logic                wide,
    output mv_form_e            form,
    output logic [SEL_W-1:0]    lane,
    output logic [LANE_W-1:0]   imm
);
    logic [DATA_W-1:0] val_eff;
    logic [DATA_W-1:0] inv_eff;
    logic [NL-1:0]     nz_val;
    logic [NL-1:0]     nz_inv;

    always_comb begin
        if (wide) begin
            val_eff = value;
            inv_eff = ~value;
        end else begin
            val_eff = {{HALF{1'b0}}, value[HALF-1:0]};
            inv_eff = {{HALF{1'b0}}, ~value[HALF-1:0]};
        end
    end

    for (genvar g = 0; g < NL; g++) begin : g_nz
        assign nz_val[g] = |val_eff[g*LANE_W +: LANE_W];
        assign nz_inv[g] = |inv_eff[g*LANE_W +: LANE_W];
    end

    logic [SEL_W-1:0] lane_val;
    logic [SEL_W-1:0] lane_inv;

    always_comb begin
        lane_val = '0;
        lane_inv = '0;
        for (int i = 0; i < NL; i++) begin
            if (nz_val[i]) lane_val = SEL_W'(i);
            if (nz_inv[i]) lane_inv = SEL_W'(i);
        end
    end

    always_comb begin
        form = FORM_NONE;
        lane = '0;
        imm  = '0;
        if ($countones(nz_val) <= 1) begin
            form = FORM_ZERO;
            lane = lane_val;
            imm  = val_eff[lane_val*LANE_W +: LANE_W];
        end else if ($countones(nz_inv) <= 1) begin
            form = FORM_NOT;
            lane = lane_inv;
            imm  = inv_eff[lane_inv*LANE_W +: LANE_W];
        end
    end
endmodule

// File: rtl/wimm_move_unit.sv
module wimm_move_unit
    import wimm_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    mv_valid,
    input  logic [1:0]              mv_op,
    input  logic [WIMM_LANE_W-1:0]  mv_imm,
    input  logic [WIMM_SEL_W-1:0]   mv_lane,
    input  logic                    mv_wide,
    input  logic [WIMM_DATA_W-1:0]  mv_dest,
    output logic                    res_valid,
    output logic [WIMM_DATA_W-1:0]  res_result,
    output logic                    res_err,
    input  logic [WIMM_DATA_W-1:0]  cls_value,
    input  logic                    cls_wide,
    output logic [1:0]              cls_form,
    output logic [WIMM_SEL_W-1:0]   cls_lane,
    output logic [WIMM_LANE_W-1:0]  cls_imm
);
    mv_ctl_t                  ctl;
    mv_res_t                  nxt;
    mv_res_t                  cur;
    logic [WIMM_DATA_W-1:0]   merged;
    mv_form_e                 form;

    assign ctl.op   = mv_op_e'(mv_op);
    assign ctl.lane = mv_lane;
    assign ctl.wide = mv_wide;
    assign ctl.imm  = mv_imm;

    wimm_lane_merge #(
        .DATA_W (WIMM_DATA_W),
        .LANE_W (WIMM_LANE_W)
    ) i_merge (
        .op     (ctl.op),
        .lane   (ctl.lane),
        .wide   (ctl.wide),
        .imm    (ctl.imm),
        .dest   (mv_dest),
        .merged (merged)
    );

    always_comb begin
        if (req_legal(ctl)) begin
            nxt.err   = 1'b0;
            nxt.value = merged;
        end else begin
            nxt.err   = 1'b1;
            nxt.value = mv_dest;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid <= 1'b0;
            cur       <= '0;
        end else begin
            res_valid <= mv_valid;
            if (mv_valid) begin
                cur <= nxt;
            end
        end
    end

    assign res_result = cur.value;
    assign res_err    = cur.err;

    wimm_form_detect #(
        .DATA_W (WIMM_DATA_W),
        .LANE_W (WIMM_LANE_W)
    ) i_detect (
        .value (cls_value),
        .wide  (cls_wide),
        .form  (form),
        .lane  (cls_lane),
        .imm   (cls_imm)
    );

    assign cls_form = form;
endmodule

// File: rtl/wimm_move_unit_chk.sv
module wimm_move_unit_chk
    import wimm_pkg::*;
(
    input logic                    clk,
    input logic                    rst,
    input logic                    mv_valid,
    input logic [1:0]              mv_op,
    input logic [WIMM_LANE_W-1:0]  mv_imm,
    input logic [WIMM_SEL_W-1:0]   mv_lane,
    input logic                    mv_wide,
    input logic [WIMM_DATA_W-1:0]  mv_dest,
    input logic                    res_valid,
    input logic [WIMM_DATA_W-1:0]  res_result,
    input logic                    res_err,
    input logic [WIMM_DATA_W-1:0]  cls_value,
    input logic                    cls_wide,
    input logic [1:0]              cls_form,
    input logic [WIMM_SEL_W-1:0]   cls_lane,
    input logic [WIMM_LANE_W-1:0]  cls_imm
);
    logic [WIMM_DATA_W-1:0] lane_mask;
    logic [WIMM_DATA_W-1:0] placed;
    logic [WIMM_DATA_W-1:0] cls_eff;
    logic                   legal;

    assign lane_mask = {{(WIMM_DATA_W-WIMM_LANE_W){1'b0}}, {WIMM_LANE_W{1'b1}}}
                       << (int'(mv_lane) * WIMM_LANE_W);
    assign placed    = {{(WIMM_DATA_W-WIMM_LANE_W){1'b0}}, mv_imm}
                       << (int'(mv_lane) * WIMM_LANE_W);
    assign legal     = (mv_op != 2'd3) && (mv_wide || !mv_lane[WIMM_SEL_W-1]);
    assign cls_eff   = cls_wide ? cls_value
                                : {{WIMM_HALF_W{1'b0}}, cls_value[WIMM_HALF_W-1:0]};

    p_valid_follows_r7: assert property (@(posedge clk) disable iff (rst)
        res_valid == $past(mv_valid));

    p_zero_policy_r1: assert property (@(posedge clk) disable iff (rst)
        (mv_valid && legal && mv_op == 2'd0) |=> res_result == $past(placed) && !res_err);

    p_not_policy_r2: assert property (@(posedge clk) disable iff (rst)
        (mv_valid && legal && mv_wide && mv_op == 2'd1) |=> res_result == ~$past(placed));

    p_keep_others_r3: assert property (@(posedge clk) disable iff (rst)
        (mv_valid && legal && mv_wide && mv_op == 2'd2) |=>
        ((res_result ^ $past(mv_dest)) & ~$past(lane_mask)) == '0);

    p_narrow_upper_r4: assert property (@(posedge clk) disable iff (rst)
        (mv_valid && legal && !mv_wide) |=> res_result[WIMM_DATA_W-1:WIMM_HALF_W] == '0);

    p_bad_lane_r5: assert property (@(posedge clk) disable iff (rst)
        (mv_valid && !mv_wide && mv_lane[WIMM_SEL_W-1]) |=>
        res_err && res_result == $past(mv_dest));

    p_reserved_op_r6: assert property (@(posedge clk) disable iff (rst)
        (mv_valid && mv_op == 2'd3) |=> res_err && res_result == $past(mv_dest));

    p_hold_idle_r7: assert property (@(posedge clk) disable iff (rst)
        !mv_valid |=> $stable(res_result) && $stable(res_err));

    p_form_zero_r9: assert property (@(posedge clk) disable iff (rst)
        (cls_form == 2'd1) |->
        cls_eff == ({{(WIMM_DATA_W-WIMM_LANE_W){1'b0}}, cls_imm} << (int'(cls_lane) * WIMM_LANE_W)));

    p_form_none_r11: assert property (@(posedge clk) disable iff (rst)
        (cls_form == 2'd0) |-> cls_lane == '0 && cls_imm == '0);
endmodule

bind wimm_move_unit wimm_move_unit_chk i_wimm_chk (
    .clk        (clk),
    .rst        (rst),
    .mv_valid   (mv_valid),
    .mv_op      (mv_op),
    .mv_imm     (mv_imm),
    .mv_lane    (mv_lane),
    .mv_wide    (mv_wide),
    .mv_dest    (mv_dest),
    .res_valid  (res_valid),
    .res_result (res_result),
    .res_err    (res_err),
    .cls_value  (cls_value),
    .cls_wide   (cls_wide),
    .cls_form   (cls_form),
    .cls_lane   (cls_lane),
    .cls_imm    (cls_imm)
);

// File: tb/test_wimm_move_unit.sv
`timescale 1ns/1ps
module test_wimm_move_unit;
    logic        clk = 1'b0;
    logic        rst;
    logic        mv_valid;
    logic [1:0]  mv_op;
    logic [15:0] mv_imm;
    logic [1:0]  mv_lane;
    logic        mv_wide;
    logic [63:0] mv_dest;
    logic        res_valid;
    logic [63:0] res_result;
    logic        res_err;
    logic [63:0] cls_value;
    logic        cls_wide;
    logic [1:0]  cls_form;
    logic [1:0]  cls_lane;
    logic [15:0] cls_imm;

    int checks = 0;
    int fails  = 0;

    logic [64:0] exp_q[$];
    string       tag_q[$];

    always #2 clk = ~clk;

    wimm_move_unit i_wimm_move_unit (
        .clk, .rst, .mv_valid, .mv_op, .mv_imm, .mv_lane, .mv_wide, .mv_dest,
        .res_valid, .res_result, .res_err,
        .cls_value, .cls_wide, .cls_form, .cls_lane, .cls_imm
    );

    task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Expected {err, result} from the requirements.
    function automatic logic [64:0] model(logic [1:0] op, logic [15:0] imm, logic [1:0] lane,
                                          logic wide, logic [63:0] dest);
        logic [63:0] sh;
        logic [63:0] mk;
        logic [63:0] r;
        if (op == 2'd3 || (!wide && lane >= 2)) return {1'b1, dest};
        sh = {48'h0, imm} << (16 * lane);
        mk = 64'hFFFF << (16 * lane);
        case (op)
            2'd0:    r = sh;
            2'd1:    r = ~sh;
            default: r = (dest & ~mk) | sh;
        endcase
        if (!wide) r[63:32] = '0;
        return {1'b0, r};
    endfunction

    task automatic drive(input string tag, input logic [1:0] op, input logic [15:0] imm,
                         input logic [1:0] lane, input logic wide, input logic [63:0] dest);
        @(negedge clk);
        mv_valid = 1'b1;
        mv_op    = op;
        mv_imm   = imm;
        mv_lane  = lane;
        mv_wide  = wide;
        mv_dest  = dest;
        exp_q.push_back(model(op, imm, lane, wide, dest));
        tag_q.push_back(tag);
    endtask

    task automatic idle();
        @(negedge clk);
        mv_valid = 1'b0;
    endtask

    task automatic classify(input string tag, input logic [63:0] v, input logic w,
                            input logic [1:0] f, input logic [1:0] l, input logic [15:0] i);
        cls_value = v;
        cls_wide  = w;
        #1;
        check(tag, {108'h0, cls_form, cls_lane, cls_imm}, {108'h0, f, l, i});
    endtask

    // Scoreboard monitor
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && res_valid) begin
                if (exp_q.size() == 0) begin
                    check("R7 unexpected result", {63'h0, res_err, res_result}, '0);
                end else begin
                    logic [64:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(t, {63'h0, res_err, res_result}, {63'h0, e});
                end
            end
        end
    end

    // Watchdog
    initial begin
        #80000;
        fails++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        rst = 1'b1;
        mv_valid = 1'b0; mv_op = '0; mv_imm = '0; mv_lane = '0; mv_wide = 1'b0;
        mv_dest = '0; cls_value = '0; cls_wide = 1'b1;
        repeat (3) @(negedge clk);
        check("R8 reset state", {62'h0, res_valid, res_err, res_result}, '0);
        rst = 1'b0;

        drive("R1 zero lane2",          2'd0, 16'hBEEF, 2'd2, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF);
        drive("R1 zero lane0",          2'd0, 16'h8001, 2'd0, 1'b1, 64'h1234_5678_9ABC_DEF0);
        drive("R2 not lane1",           2'd1, 16'h1234, 2'd1, 1'b1, 64'h0);
        drive("R3 keep lane3",          2'd2, 16'hABCD, 2'd3, 1'b1, 64'h1111_2222_3333_4444);
        drive("R3 keep lane1",          2'd2, 16'h0000, 2'd1, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF);
        drive("R4 narrow keep",         2'd2, 16'h7777, 2'd1, 1'b0, 64'hFFFF_FFFF_5555_6666);
        drive("R4 narrow not",          2'd1, 16'h0000, 2'd0, 1'b0, 64'hAAAA_AAAA_AAAA_AAAA);
        drive("R4 narrow zero lane1",   2'd0, 16'hC3C3, 2'd1, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF);
        drive("R5 narrow lane3",        2'd0, 16'h1111, 2'd3, 1'b0, 64'hDEAD_BEEF_0BAD_F00D);
        drive("R5 narrow lane2 keep",   2'd2, 16'h2222, 2'd2, 1'b0, 64'h0123_4567_89AB_CDEF);
        drive("R6 reserved op",         2'd3, 16'h3333, 2'd0, 1'b1, 64'hCAFE_0000_FACE_0001);
        idle();

        // R7 single strobe latency and hold
        drive("R7 single strobe",       2'd0, 16'h00FF, 2'd3, 1'b1, 64'h0);
        idle();
        check("R7 valid next cycle", {127'h0, res_valid}, 128'h1);
        @(negedge clk);
        begin
            logic [63:0] held;
            held = res_result;
            repeat (3) @(negedge clk);
            check("R7 idle no valid", {127'h0, res_valid}, 128'h0);
            check("R7 result held", {64'h0, res_result}, {64'h0, held});
        end

        classify("R9 zero constant",        64'h0,                   1'b1, 2'd1, 2'd0, 16'h0000);
        classify("R9 zero form lane2",      64'h0000_BEEF_0000_0000, 1'b1, 2'd1, 2'd2, 16'hBEEF);
        classify("R10 not form wide",       64'hFFFF_FFFF_FFFF_1234, 1'b1, 2'd2, 2'd0, 16'hEDCB);
        classify("R10 prefer zero narrow",  64'h0000_0000_FFFF_0000, 1'b0, 2'd1, 2'd1, 16'hFFFF);
        classify("R10 not form narrow",     64'h0000_0000_FFFF_FFFF, 1'b0, 2'd2, 2'd0, 16'h0000);
        classify("R11 none two lanes",      64'h0000_0001_0001_0000, 1'b1, 2'd0, 2'd0, 16'h0000);
        classify("R11 none half ones",      64'h0000_0000_FFFF_FFFF, 1'b1, 2'd0, 2'd0, 16'h0000);
        classify("R12 narrow upper ignored",64'hABCD_0000_0000_1234, 1'b0, 2'd1, 2'd0, 16'h1234);
        classify("R12 narrow upper ones",   64'hFFFF_FFFF_5A5A_FFFF, 1'b0, 2'd2, 2'd1, 16'hA5A5);

        repeat (2) @(negedge clk);
        check("R7 all results seen", {96'h0, 32'(exp_q.size())}, '0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule